// File: doc/BRIEF.md
# Broadcast-tile int8 matrix-vector sequencer

This block computes one row of an activation matrix times a weight matrix that has already been stored in an interleaved tile layout. Each step fetches one 32-bit group of four unsigned 8-bit activations and copies it to all lanes of a 16-lane dot-product datapath. In the same step it fetches one 512-bit weight word that gives every lane four signed 8-bit weights. Each lane forms a four-term dot product and adds it into its own 32-bit accumulator.

When the whole row has been consumed, the 16 accumulators are presented as one 512-bit result. The same row is then read again against the following weight words for the next group of 16 output columns. This repeats until the configured column count is covered. The weight address runs linearly across all groups, so the weight memory is read as a single stream.

The sequencer accepts a job on a start pulse, but only when the row length and column count are legal. It flags an illegal configuration. It also accounts for the latency of the dot-product pipeline, so each result is marked valid only after its last accumulate has retired.

Top module: `mv_tile_seq`

## Requirements
- R1: A start while idle is accepted only if the row length is a nonzero multiple of 4 and the column count is a nonzero multiple of 16. Otherwise `cfg_err_o` goes high in the next cycle, no read request is made, and `busy_o` stays low. `cfg_err_o` stays high until a start is accepted.
- R2: For every step, `a_req_o` is high and `a_addr_o` is the step index k within the row, running 0 to row_len/4-1 and then restarting for each column group. The memory returns `a_data_i` in the next cycle. Byte j (bits 8j+7:8j) of that word is the unsigned activation with index 4k+j.
- R3: `w_req_o` is high in the same cycles as `a_req_o`. `w_addr_o` starts at 0 in the first step of a job and rises by exactly one per step across all column groups, for (row_len/4)*(col_cnt/16) steps issued on consecutive cycles. `w_data_i` returns in the next cycle.
- R4: Lane c (c = 0..15) adds, for every step, the sum over j = 0..3 of activation byte j times the signed weight byte at bits 32c+8j+7:32c+8j of that step's weight word.
- R5: The result for lane c is at bits 32c+31:32c of `res_data_o` as a two's-complement 32-bit value. This holds for the most negative products (255 times -128).
- R6: Each column group's result depends only on that group's steps. The accumulators restart at zero for every group and every job.
- R7: `res_valid_o` is high for exactly one cycle per column group, in group order, exactly 3 cycles after the request cycle of that group's last step.
- R8: `done_o` is high together with the final group's `res_valid_o`. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and low in the cycle after it.
- R9: A start that arrives while a job is running is ignored and does not change that job's addresses or results.
- R10: After reset `busy_o`, `a_req_o`, `w_req_o`, `res_valid_o`, `done_o` and `cfg_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job start pulse |
| row_len_i | input | 12 | Row length in activations |
| col_cnt_i | input | 12 | Number of output columns |
| a_req_o | output | 1 | Activation read request |
| a_addr_o | output | 10 | Activation word address |
| a_data_i | input | 32 | Activation word, one cycle after request |
| w_req_o | output | 1 | Weight read request |
| w_addr_o | output | 18 | Weight word address |
| w_data_i | input | 512 | Weight word, one cycle after request |
| busy_o | output | 1 | Job in progress |
| cfg_err_o | output | 1 | Last start had an illegal configuration |
| res_valid_o | output | 1 | Result word valid |
| res_data_o | output | 512 | 16 signed 32-bit lane results |
| done_o | output | 1 | Final result of the job |

## Verification
The smallest job (one step, one group) separates the pipeline latency from the accumulation. Multi-step, multi-group jobs with random data show whether lanes are wired to the right weight slots, whether the activation is truly broadcast, and whether the accumulators restart at each group. A one-step-per-group job produces results on consecutive cycles, which exposes any gap or overlap between groups. All-maximum operands check signed and unsigned handling at the extremes. Illegal lengths, a zero length, and a start pulse in the middle of a job check that the configuration gate holds and that a running job is never disturbed.

// File: rtl/mv_pkg.sv
package mv_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_DRAIN
  } seq_state_t;

  typedef struct packed {
    logic v;
    logic first;
    logic last;
    logic fin;
  } step_flags_t;

  // unsigned activation bytes times signed weight bytes, four terms
  function automatic logic signed [31:0] dot4(input logic [31:0] a, input logic [31:0] w);
    logic signed [31:0] s;
    logic signed [8:0]  av;
    logic signed [7:0]  wv;
    logic signed [16:0] p;
    s = '0;
    for (int j = 0; j < 4; j++) begin
      av = $signed({1'b0, a[8*j +: 8]});
      wv = $signed(w[8*j +: 8]);
      p  = av * wv;
      s  = s + 32'(p);
    end
    return s;
  endfunction

endpackage

// File: rtl/mv_lane.sv
module mv_lane #(
  parameter int DOT_STAGES = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] a_word_i,
  input  logic [31:0] w_slot_i,
  input  logic        acc_en_i,
  input  logic        acc_clr_i,
  output logic [31:0] acc_o
);

  logic signed [31:0] dot_q [DOT_STAGES];
  logic signed [31:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DOT_STAGES; i++) dot_q[i] <= '0;
    end else begin
      dot_q[0] <= mv_pkg::dot4(a_word_i, w_slot_i);
      for (int i = 1; i < DOT_STAGES; i++) dot_q[i] <= dot_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en_i) begin
      acc_q <= acc_clr_i ? dot_q[DOT_STAGES-1] : acc_q + dot_q[DOT_STAGES-1];
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mv_flag_pipe.sv
module mv_flag_pipe #(
  parameter int DOT_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic first_i,
  input  logic last_i,
  input  logic final_i,
  output logic acc_en_o,
  output logic acc_clr_o,
  output logic res_valid_o,
  output logic done_o
);
  import mv_pkg::*;

  localparam int NSTG = DOT_STAGES + 1;

  // stage 0: read data present; stage NSTG-1: accumulate
  step_flags_t stg_q [NSTG];
  logic        res_valid_q;
  logic        done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTG; i++) stg_q[i] <= '0;
      res_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      stg_q[0] <= '{v: issue_i, first: first_i, last: last_i, fin: final_i};
      for (int i = 1; i < NSTG; i++) stg_q[i] <= stg_q[i-1];
      res_valid_q <= stg_q[NSTG-1].v & stg_q[NSTG-1].last;
      done_q      <= stg_q[NSTG-1].v & stg_q[NSTG-1].fin;
    end
  end

  assign acc_en_o    = stg_q[NSTG-1].v;
  assign acc_clr_o   = stg_q[NSTG-1].first;
  assign res_valid_o = res_valid_q;
  assign done_o      = done_q;

endmodule

// File: rtl/mv_step_ctrl.sv
module mv_step_ctrl #(
  parameter int LEN_W = 12,
  parameter int LANES = 16,
  localparam int LG  = $clog2(LANES),
  localparam int KW  = LEN_W - 2,
  localparam int GW  = LEN_W - LG,
  localparam int WAW = KW + GW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] row_len_i,
  input  logic [LEN_W-1:0] col_cnt_i,
  input  logic             done_i,
  output logic             issue_o,
  output logic             first_o,
  output logic             last_o,
  output logic             final_o,
  output logic [KW-1:0]    a_addr_o,
  output logic [WAW-1:0]   w_addr_o,
  output logic             busy_o,
  output logic             cfg_err_o
);
  import mv_pkg::*;

  seq_state_t     st_q;
  logic [KW-1:0]  k_q, kmax_q;
  logic [GW-1:0]  g_q, gmax_q;
  logic [WAW-1:0] w_q;
  logic           err_q;
  logic           cfg_ok;

  assign cfg_ok = (row_len_i != '0) && (row_len_i[1:0] == 2'b00) &&
                  (col_cnt_i != '0) && (col_cnt_i[LG-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      k_q    <= '0;
      kmax_q <= '0;
      g_q    <= '0;
      gmax_q <= '0;
      w_q    <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            if (cfg_ok) begin
              st_q   <= S_RUN;
              kmax_q <= row_len_i[LEN_W-1:2] - KW'(1);
              gmax_q <= col_cnt_i[LEN_W-1:LG] - GW'(1);
              k_q    <= '0;
              g_q    <= '0;
              w_q    <= '0;
              err_q  <= 1'b0;
            end else begin
              err_q  <= 1'b1;
            end
          end
        end
        S_RUN: begin
          w_q <= w_q + WAW'(1);
          if (k_q == kmax_q) begin
            k_q <= '0;
            if (g_q == gmax_q) st_q <= S_DRAIN;
            else               g_q  <= g_q + GW'(1);
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        S_DRAIN: if (done_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign issue_o   = (st_q == S_RUN);
  assign first_o   = (k_q == '0);
  assign last_o    = (k_q == kmax_q);
  assign final_o   = (k_q == kmax_q) && (g_q == gmax_q);
  assign a_addr_o  = k_q;
  assign w_addr_o  = w_q;
  assign busy_o    = (st_q != S_IDLE);
  assign cfg_err_o = err_q;

endmodule

// File: rtl/mv_tile_seq.sv
module mv_tile_seq #(
  parameter int LEN_W      = 12,
  parameter int LANES      = 16,
  parameter int DOT_STAGES = 1,
  localparam int LG  = $clog2(LANES),
  localparam int KW  = LEN_W - 2,
  localparam int WAW = KW + LEN_W - LG,
  localparam int DW  = LANES * 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] row_len_i,
  input  logic [LEN_W-1:0] col_cnt_i,
  output logic             a_req_o,
  output logic [KW-1:0]    a_addr_o,
  input  logic [31:0]      a_data_i,
  output logic             w_req_o,
  output logic [WAW-1:0]   w_addr_o,
  input  logic [DW-1:0]    w_data_i,
  output logic             busy_o,
  output logic             cfg_err_o,
  output logic             res_valid_o,
  output logic [DW-1:0]    res_data_o,
  output logic             done_o
);

  logic issue, first, last, fin;
  logic acc_en, acc_clr;

  mv_step_ctrl #(.LEN_W(LEN_W), .LANES(LANES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .row_len_i (row_len_i),
    .col_cnt_i (col_cnt_i),
    .done_i    (done_o),
    .issue_o   (issue),
    .first_o   (first),
    .last_o    (last),
    .final_o   (fin),
    .a_addr_o  (a_addr_o),
    .w_addr_o  (w_addr_o),
    .busy_o    (busy_o),
    .cfg_err_o (cfg_err_o)
  );

  mv_flag_pipe #(.DOT_STAGES(DOT_STAGES)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .first_i     (first),
    .last_i      (last),
    .final_i     (fin),
    .acc_en_o    (acc_en),
    .acc_clr_o   (acc_clr),
    .res_valid_o (res_valid_o),
    .done_o      (done_o)
  );

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    mv_lane #(.DOT_STAGES(DOT_STAGES)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .a_word_i  (a_data_i),
      .w_slot_i  (w_data_i[32*c +: 32]),
      .acc_en_i  (acc_en),
      .acc_clr_i (acc_clr),
      .acc_o     (res_data_o[32*c +: 32])
    );
  end

  assign a_req_o = issue;
  assign w_req_o = issue;

endmodule

// File: rtl/mv_tile_seq_chk.sv
module mv_tile_seq_chk #(
  parameter int A_AW = 10,
  parameter int W_AW = 18
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            cfg_err_o,
  input logic            a_req_o,
  input logic [A_AW-1:0] a_addr_o,
  input logic            w_req_o,
  input logic [W_AW-1:0] w_addr_o,
  input logic            res_valid_o,
  input logic            done_o
);

  assert_err_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!busy_o && !a_req_o && !w_req_o))
    else $error("R1: error flag with activity");

  assert_aaddr_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_req_o && $past(a_req_o) && a_addr_o != '0) |-> a_addr_o == $past(a_addr_o) + A_AW'(1))
    else $error("R2: activation address skipped");

  assert_req_in_job_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_req_o |-> busy_o)
    else $error("R2: request outside job");

  assert_waddr_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_req_o && $past(w_req_o)) |-> w_addr_o == $past(w_addr_o) + W_AW'(1))
    else $error("R3: weight address not linear");

  assert_waddr_origin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (w_req_o && w_addr_o == '0))
    else $error("R3: job does not begin at weight word 0");

  assert_result_in_job_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o)
    else $error("R7: result outside job");

  assert_done_with_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> res_valid_o)
    else $error("R8: done without result");

  assert_done_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o)
    else $error("R8: busy held after done");

endmodule

bind mv_tile_seq mv_tile_seq_chk #(.A_AW(KW), .W_AW(WAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .cfg_err_o   (cfg_err_o),
  .a_req_o     (a_req_o),
  .a_addr_o    (a_addr_o),
  .w_req_o     (w_req_o),
  .w_addr_o    (w_addr_o),
  .res_valid_o (res_valid_o),
  .done_o      (done_o)
);

// File: tb/mv_tile_seq_test.sv
`timescale 1ns/1ps
module mv_tile_seq_test;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [11:0]  row_len_i = '0;
  logic [11:0]  col_cnt_i = '0;
  logic         a_req_o, w_req_o;
  logic [9:0]   a_addr_o;
  logic [17:0]  w_addr_o;
  logic [31:0]  a_data_i = '0;
  logic [511:0] w_data_i = '0;
  logic         busy_o, cfg_err_o, res_valid_o, done_o;
  logic [511:0] res_data_o;

  always #2.5 clk = ~clk;

  mv_tile_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .row_len_i(row_len_i), .col_cnt_i(col_cnt_i),
    .a_req_o(a_req_o), .a_addr_o(a_addr_o), .a_data_i(a_data_i),
    .w_req_o(w_req_o), .w_addr_o(w_addr_o), .w_data_i(w_data_i),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .done_o(done_o)
  );

  byte unsigned amem [0:255];
  byte          wmem [0:8191];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_k = 1;
  int exp_w = 0;
  int exp_k = 0;
  int nreq = 0;
  logic [511:0] exp_q [$];
  int           vcyc_q [$];

  // memory with one cycle of read latency
  always @(posedge clk) begin
    if (a_req_o)
      for (int j = 0; j < 4; j++) a_data_i[8*j +: 8] <= amem[4*int'(a_addr_o) + j];
    if (w_req_o)
      for (int b = 0; b < 64; b++) w_data_i[8*b +: 8] <= wmem[64*int'(w_addr_o) + b];
  end

  task automatic check(input bit ok, input string req, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s expected %s", req, act, expv);
    end
  endtask

  // reference model, evaluated every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (w_req_o || a_req_o) begin
        nreq++;
        check(a_req_o && w_req_o, "R3 req pairing", $sformatf("%0b/%0b", a_req_o, w_req_o), "1/1");
        check(int'(w_addr_o) == exp_w, "R3 w_addr", $sformatf("%0d", w_addr_o), $sformatf("%0d", exp_w));
        check(int'(a_addr_o) == exp_k, "R2 a_addr", $sformatf("%0d", a_addr_o), $sformatf("%0d", exp_k));
        if (exp_k == cur_k - 1) vcyc_q.push_back(cyc + 3);
        exp_w++;
        exp_k = (exp_k + 1 == cur_k) ? 0 : exp_k + 1;
      end
      if (res_valid_o) begin
        if (exp_q.size() == 0 || vcyc_q.size() == 0) begin
          check(1'b0, "R7 extra result", "result", "none");
        end else begin
          logic [511:0] e;
          int           ec;
          e  = exp_q.pop_front();
          ec = vcyc_q.pop_front();
          check(res_data_o == e, "R4 R5 R6 result", $sformatf("%h", res_data_o), $sformatf("%h", e));
          check(cyc == ec, "R7 result cycle", $sformatf("%0d", cyc), $sformatf("%0d", ec));
          if (done_o) check(exp_q.size() == 0, "R8 done on last group",
                            $sformatf("%0d left", exp_q.size()), "0 left");
          else        check(exp_q.size() != 0, "R8 done missing", "no done", "done");
        end
      end else if (done_o) begin
        check(1'b0, "R8 done without result", "done", "res_valid");
      end
    end
  end

  task automatic fill_random();
    for (int i = 0; i < 256; i++)  amem[i] = 8'($urandom);
    for (int i = 0; i < 8192; i++) wmem[i] = 8'($urandom);
  endtask

  task automatic build_exp(input int rl, input int cc);
    int k;
    int g;
    k = rl / 4;
    g = cc / 16;
    for (int gi = 0; gi < g; gi++) begin
      logic [511:0] r;
      for (int c = 0; c < 16; c++) begin
        int s;
        s = 0;
        for (int ki = 0; ki < k; ki++)
          for (int j = 0; j < 4; j++)
            s += int'(amem[4*ki + j]) * int'(wmem[(gi*k + ki)*64 + 4*c + j]);
        r[32*c +: 32] = s;
      end
      exp_q.push_back(r);
    end
  endtask

  task automatic pulse_start(input int rl, input int cc);
    @(posedge clk); #1;
    start_i = 1'b1;
    row_len_i = 12'(rl);
    col_cnt_i = 12'(cc);
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic run_job(input int rl, input int cc);
    build_exp(rl, cc);
    cur_k = rl / 4;
    exp_w = 0;
    exp_k = 0;
    pulse_start(rl, cc);
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 1'b0;
    for (int n = 0; n < 20000 && !seen; n++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    check(seen, {"R8 done reached ", tag}, "timeout", "done");
    @(negedge clk);
    check(!busy_o, {"R8 busy released ", tag}, $sformatf("%0b", busy_o), "0");
    check(exp_q.size() == 0, {"R7 all groups delivered ", tag},
          $sformatf("%0d", exp_q.size()), "0");
  endtask

  task automatic bad_start(input int rl, input int cc, input string tag);
    int n0;
    n0 = nreq;
    pulse_start(rl, cc);
    @(negedge clk);
    check(cfg_err_o, {"R1 error flag ", tag}, $sformatf("%0b", cfg_err_o), "1");
    check(!busy_o, {"R1 not busy ", tag}, $sformatf("%0b", busy_o), "0");
    repeat (5) @(negedge clk);
    check(nreq == n0, {"R1 no requests ", tag}, $sformatf("%0d", nreq - n0), "0");
    check(cfg_err_o, {"R1 error held ", tag}, $sformatf("%0b", cfg_err_o), "1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: got hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check({busy_o, a_req_o, w_req_o, res_valid_o, done_o, cfg_err_o} == 6'b0, "R10 reset outputs",
          $sformatf("%b", {busy_o, a_req_o, w_req_o, res_valid_o, done_o, cfg_err_o}), "000000");
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    // smallest job: one step, one group
    fill_random();
    run_job(4, 16);
    wait_done("4x16");

    // several steps and groups, R6 restart per group
    fill_random();
    run_job(12, 48);
    wait_done("12x48");

    // R5 extremes: 255 * -128
    for (int i = 0; i < 256; i++)  amem[i] = 8'hFF;
    for (int i = 0; i < 8192; i++) wmem[i] = -128;
    run_job(8, 16);
    wait_done("extreme");

    // R1 illegal configurations
    bad_start(6, 16, "row 6");
    bad_start(8, 24, "col 24");
    bad_start(0, 16, "row 0");

    // accepted start clears the error
    fill_random();
    run_job(16, 32);
    @(negedge clk);
    check(!cfg_err_o, "R1 error cleared", $sformatf("%0b", cfg_err_o), "0");
    check(busy_o, "R8 busy after start", $sformatf("%0b", busy_o), "1");
    wait_done("16x32");

    // R9 start during a running job
    fill_random();
    run_job(20, 16);
    repeat (2) @(posedge clk);
    #1;
    start_i = 1'b1;
    row_len_i = 12'd4;
    col_cnt_i = 12'd64;
    @(posedge clk); #1;
    start_i = 1'b0;
    wait_done("R9 busy start");

    // one step per group: back-to-back results (R7)
    fill_random();
    run_job(4, 64);
    wait_done("4x64");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule